// File: doc/BRIEF.md
# Byte-Field Multiply Unit

This unit does arithmetic on symbols of a binary extension field. Its core is a one-step multiply by the field generator x. The symbol moves up one bit position and the bit that falls off the top is dropped. That bit then decides whether a fixed reduction constant is XORed into the result. For 8-bit symbols the constant is 0x1D, which gives the field polynomial x^8+x^4+x^3+x^2+1. In hardware this step is a few XOR gates on the bit positions where the constant has ones. No decision logic is needed, so one cycle replaces a software sequence of shift, mask test, branch and exclusive-or.

The same step also drives a sequential general multiplier. A start strobe captures operands A and B and clears an accumulator. The unit then makes one pass per bit of B, starting at the top bit. Each pass multiplies the accumulator by x and XORs in A when the current bit of B is one. After the last pass the product is registered and a one-cycle done strobe is raised. The one-step multiply is also available on its own combinational port, for code that only needs that operation.

Top module: `gf_mulx_unit`

## Requirements
- R1: When bit W-1 of `xt_in` is 0, `xt_out` equals `xt_in` shifted up by one position, with 0 entering bit 0 and the top bit dropped.
- R2: When bit W-1 of `xt_in` is 1, `xt_out` equals the shifted value XOR the reduction constant `POLY`. The default constant is 0x1D for W=8.
- R3: The product delivered with `done` equals A·B in GF(2^W) reduced by x^W + `POLY`. This includes the zero operand and the identity operand 1.
- R4: `done` is high for exactly one cycle. It rises on the W-th rising edge after the edge that samples `start`, so the bench sees it W+1 cycles after it raises `start`.
- R5: A `start` that arrives while a multiply is in progress is ignored. The running operation keeps its operands, its result and its timing.
- R6: After synchronous reset, `done` is 0 and `product` is 0.
- R7: `product` holds its value between completions. It changes only on the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply when idle |
| op_a | input | W | Multiplicand, sampled with start |
| op_b | input | W | Multiplier, sampled with start |
| product | output | W | Registered product |
| done | output | 1 | One-cycle completion strobe |
| xt_in | input | W | Operand for the combinational multiply-by-x |
| xt_out | output | W | Combinational multiply-by-x result |

## Verification
The bench builds two instances. The first uses W=8 with POLY=0x1D. The second uses W=4 with POLY=0x3, the field x^4+x+1. In the 4-bit instance every one of the 256 operand pairs fits in a few thousand cycles, so every product and every reduction path is checked exhaustively. The 8-bit instance is checked over its full 256-value one-step table. Its multiplier is run with every A against the boundary B values 0, 1, 2, 0x80 and 0xFF and one varied pattern, plus a stream of pseudo-random pairs. Both widths are checked against a reference that multiplies LSB-first, the opposite scan order to the hardware.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} gf_state_e;
  localparam int unsigned GF_DEF_W    = 8;
  localparam int unsigned GF_DEF_POLY = 32'h1D;
endpackage

// File: rtl/gf_xtime.sv
module gf_xtime #(
  parameter int unsigned W    = 8,
  parameter int unsigned POLY = 32'h1D
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] P = POLY[W-1:0];

  // Per-bit XOR wiring: shifted bit plus reduction tap keyed on the old MSB.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign y[0] = a[W-1] & P[0];
    end else begin : g_up
      assign y[i] = a[i-1] ^ (a[W-1] & P[i]);
    end
  end

  // R1: with a clear MSB nothing can be folded into bit 0
  always_comb begin
    assert_xtime_lsb_R1: assert (a[W-1] || (y[0] == 1'b0));
  end
endmodule

// File: rtl/gf_mul_ctrl.sv
module gf_mul_ctrl
  import gf_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  gf_state_e     st;
  logic [CW-1:0] cnt;

  assign load = (st == ST_IDLE) && start;
  assign step = (st == ST_RUN);
  assign last = step && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        st  <= ST_RUN;
        cnt <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st == ST_RUN));

  assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && cnt != LAST_IDX) |=> (st == ST_RUN && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/gf_mul_acc.sv
module gf_mul_acc #(
  parameter int unsigned W    = 8,
  parameter int unsigned POLY = 32'h1D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         last,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] product
);
  logic [W-1:0] a_q, b_q, acc, acc_x, acc_nx;

  gf_xtime #(.W(W), .POLY(POLY)) xt_acc_i (.a(acc), .y(acc_x));

  assign acc_nx = acc_x ^ (b_q[W-1] ? a_q : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      acc     <= '0;
      product <= '0;
    end else begin
      if (load) begin
        a_q <= a_in;
        b_q <= b_in;
        acc <= '0;
      end else if (step) begin
        acc <= acc_nx;
        b_q <= {b_q[W-2:0], 1'b0};
        if (last) product <= acc_nx;
      end
    end
  end

  assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(product));
endmodule

// File: rtl/gf_mulx_unit.sv
module gf_mulx_unit #(
  parameter int unsigned W    = gf_pkg::GF_DEF_W,
  parameter int unsigned POLY = gf_pkg::GF_DEF_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] product,
  output logic         done,
  input  logic [W-1:0] xt_in,
  output logic [W-1:0] xt_out
);
  logic load, step, last;

  gf_mul_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .last(last), .done(done)
  );

  gf_mul_acc #(.W(W), .POLY(POLY)) acc_i (
    .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
    .a_in(op_a), .b_in(op_b), .product(product)
  );

  gf_xtime #(.W(W), .POLY(POLY)) xt_port_i (.a(xt_in), .y(xt_out));
endmodule

// File: tb/gf_mulx_unit_tb_top.sv
`timescale 1ns/1ps
module gf_mulx_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;

  // 8-bit instance
  logic       st8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0, p8, xi8 = '0, xo8;
  logic       d8;
  // 4-bit instance
  logic       st4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0, p4, xi4 = '0, xo4;
  logic       d4;

  gf_mulx_unit #(.W(8), .POLY(32'h1D)) dut_i (
    .clk(clk), .rst(rst), .start(st8), .op_a(a8), .op_b(b8),
    .product(p8), .done(d8), .xt_in(xi8), .xt_out(xo8));

  gf_mulx_unit #(.W(4), .POLY(32'h3)) dut4_i (
    .clk(clk), .rst(rst), .start(st4), .op_a(a4), .op_b(b4),
    .product(p4), .done(d4), .xt_in(xi4), .xt_out(xo4));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: LSB-first shift-and-add with explicit reduction
  function automatic int ref_xt(input int v, input int w, input int poly);
    int m = (1 << w) - 1;
    int r = (v << 1) & m;
    if ((v >> (w - 1)) & 1) r = r ^ poly;
    return r;
  endfunction

  function automatic int ref_mul(input int a, input int b, input int w, input int poly);
    int r = 0;
    int aa = a;
    for (int i = 0; i < w; i++) begin
      if ((b >> i) & 1) r = r ^ aa;
      aa = ref_xt(aa, w, poly);
    end
    return r;
  endfunction

  task automatic mul8(input logic [7:0] a, input logic [7:0] b, output int prod, output int lat);
    @(negedge clk); a8 = a; b8 = b; st8 = 1'b1;
    @(negedge clk); st8 = 1'b0; lat = 1;
    while (!d8 && lat < 40) begin @(negedge clk); lat++; end
    prod = p8;
  endtask

  task automatic mul4(input logic [3:0] a, input logic [3:0] b, output int prod, output int lat);
    @(negedge clk); a4 = a; b4 = b; st4 = 1'b1;
    @(negedge clk); st4 = 1'b0; lat = 1;
    while (!d4 && lat < 40) begin @(negedge clk); lat++; end
    prod = p4;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R6 done8 after reset", d8, 0);
    chk("R6 product8 after reset", p8, 0);
    chk("R6 done4 after reset", d4, 0);
    chk("R6 product4 after reset", p4, 0);
  endtask

  task automatic t_xtime;
    for (int v = 0; v < 256; v++) begin
      xi8 = 8'(v); #1;
      chk(v[7] ? "R2 xtime8 reduce" : "R1 xtime8 shift", xo8, ref_xt(v, 8, 32'h1D));
    end
    for (int v = 0; v < 16; v++) begin
      xi4 = 4'(v); #1;
      chk(v[3] ? "R2 xtime4 reduce" : "R1 xtime4 shift", xo4, ref_xt(v, 4, 3));
    end
    xi8 = 8'h80; #1; chk("R2 xtime8 0x80 gives poly", xo8, 8'h1D);
    xi8 = 8'h7F; #1; chk("R1 xtime8 0x7F", xo8, 8'hFE);
  endtask

  task automatic t_exhaustive4;
    int p, l;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        mul4(4'(a), 4'(b), p, l);
        chk("R3 mul4 product", p, ref_mul(a, b, 4, 3));
        chk("R4 mul4 latency", l, 5);
      end
  endtask

  task automatic t_sweep8;
    int p, l;
    int bs[6];
    for (int a = 0; a < 256; a++) begin
      bs = '{0, 1, 2, 8'h80, 8'hFF, (a ^ 8'h5A)};
      foreach (bs[k]) begin
        mul8(8'(a), 8'(bs[k]), p, l);
        chk("R3 mul8 boundary product", p, ref_mul(a, bs[k], 8, 32'h1D));
      end
    end
  endtask

  task automatic t_random8;
    int p, l;
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mul8(lf[15:8], lf[7:0], p, l);
      chk("R3 mul8 random product", p, ref_mul(lf[15:8], lf[7:0], 8, 32'h1D));
    end
  endtask

  task automatic t_timing;
    int p, l;
    mul8(8'h57, 8'h83, p, l);
    chk("R4 mul8 latency", l, 9);
    @(negedge clk);
    chk("R4 done single cycle", d8, 0);
  endtask

  task automatic t_busy_start;
    int lat;
    @(negedge clk); a8 = 8'hC3; b8 = 8'h2B; st8 = 1'b1;
    @(negedge clk); st8 = 1'b0; lat = 1;
    @(negedge clk); lat++;
    @(negedge clk); lat++;
    a8 = 8'h11; b8 = 8'hEE; st8 = 1'b1;
    @(negedge clk); st8 = 1'b0; lat++;
    while (!d8 && lat < 40) begin @(negedge clk); lat++; end
    chk("R5 busy start ignored, product", p8, ref_mul(8'hC3, 8'h2B, 8, 32'h1D));
    chk("R5 busy start ignored, latency", lat, 9);
    repeat (12) begin
      @(negedge clk);
      chk("R5 no second done", d8, 0);
    end
  endtask

  task automatic t_hold;
    int p, l;
    mul8(8'h9A, 8'h3C, p, l);
    a8 = 8'hFF; b8 = 8'hFF;
    repeat (10) begin
      @(negedge clk);
      chk("R7 product held", p8, ref_mul(8'h9A, 8'h3C, 8, 32'h1D));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_xtime();
    t_timing();
    t_exhaustive4();
    t_sweep8();
    t_random8();
    t_busy_start();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule